// File: doc/BRIEF.md
# Region Coherence State Tracker

This block runs beside one processor's private cache. It tracks coherence for whole aligned regions rather than for single lines. A region is a power-of-two group of lines. It can be as small as two lines and as large as one page. Each tracked region holds three things:

- a tag,
- a three-bit region state that combines the local status with the status seen in other processors,
- a count of how many lines of that region sit in the local cache.

On a local miss, the block reports whether the request must be broadcast to other processors or may go straight to memory. It also reports whether a speculative DRAM read may be started alongside the broadcast.

On an external snoop, it returns a two-bit region response. It also tells the cache whether a tag lookup is needed at all; lookups for regions the cache cannot hold are filtered out.

Line fills and line evictions from the cache keep the count and the state current. Each fill carries the combined region response gathered from the other processors. If a new region must displace one that still has cached lines, the block asks the cache to back-invalidate the old region. It holds the new region until that request is acknowledged.

Top module: `region_tracker`

## Requirements
- R1: After reset every region is invalid: any lookup misses and reports state 3'b000 (I) with broadcast required.
- R2: A lookup presented in one cycle is answered in the next cycle. The answer reflects every fill, line eviction and snoop update accepted in earlier cycles.
- R3: State encoding: bit 2 is set when local copies may be dirty. Bits 1:0 give the remote status: 01 none, 10 clean only, 11 possibly dirty. 3'b000 is I. Broadcast is needed when bits 1:0 are 00 or 11. It is not needed for 01. For 10 it is needed only when a modifiable copy is requested.
- R4: The speculative-read flag is 0 in each of these cases:
  - no broadcast is needed;
  - the remote status is 11;
  - the state is I and the configuration input that suppresses speculation on unknown regions is 1.

  Otherwise it is 1.
- R5: A fill to a region that is already tracked works as follows:
  - the local bit becomes the old local bit OR the fill's dirty flag;
  - the remote bits become the fill's response (dirty gives 11, else clean gives 10, else 01) only when the fill was broadcast;
  - otherwise the remote bits are kept.

  A fill that allocates a region takes its local bit from the fill and its remote bits from the response.
- R6: A snoop is answered one cycle later. The clean bit is 1 when the region is tracked with bit 2 clear. The dirty bit is 1 when the region is tracked with bit 2 set. Both are 0 for an untracked region.
- R7: The cache-lookup forward bit of a snoop answer is 1 only when the region is tracked and its line count is nonzero.
- R8: A snoop that hits sets the remote bits to 11 if it asks for a modifiable copy or the bits already read 11. Otherwise it sets them to 10. The local bit is unchanged.
- R9: The line count rises by one per fill, up to the number of lines in a region. It falls by one per line eviction and stops at zero.
- R10: A new region takes a free way first. Failing that it takes a way whose count is zero, using the least-recently-used way when both are zero. Such a displacement needs no back-invalidate. A region never occupies two ways of a set.
- R11: When both ways hold nonzero counts, the block raises busy and a back-invalidate request carrying the base address of the least-recently-used region. That address is held steady. Fills are ignored until the acknowledge, in whose cycle the new region is installed with count 1.
- R12: A lookup hit, a fill hit or an install makes the touched way most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nospec_unknown | input | 1 | Suppress speculative DRAM reads for regions in state I |
| req_valid | input | 1 | Local miss lookup strobe |
| req_addr | input | ADDR_W | Local miss address |
| req_want_mod | input | 1 | Local miss needs a modifiable copy |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Region tracked |
| rsp_state | output | 3 | Region state (I when untracked) |
| rsp_bcast | output | 1 | Broadcast required |
| rsp_spec_ok | output | 1 | Speculative DRAM read allowed |
| snp_valid | input | 1 | External snoop strobe |
| snp_addr | input | ADDR_W | Snoop address |
| snp_want_mod | input | 1 | Snooper requests a modifiable copy |
| snp_rsp_valid | output | 1 | Snoop answer valid |
| snp_ext_clean | output | 1 | Region response: clean copies here |
| snp_ext_dirty | output | 1 | Region response: possibly dirty copies here |
| snp_fwd | output | 1 | Pass snoop on to the cache tag lookup |
| fill_valid | input | 1 | Line fill into local cache |
| fill_addr | input | ADDR_W | Fill address |
| fill_dirty | input | 1 | Fill is a modifiable copy |
| fill_bcast | input | 1 | Fill came from a broadcast, so its response is meaningful |
| fill_ext_clean | input | 1 | Combined region response: clean elsewhere |
| fill_ext_dirty | input | 1 | Combined region response: dirty elsewhere |
| evict_valid | input | 1 | Local line evicted or invalidated |
| evict_addr | input | ADDR_W | Evicted line address |
| busy | output | 1 | Waiting on a back-invalidate |
| binv_req | output | 1 | Back-invalidate request |
| binv_addr | output | ADDR_W | Base address of the region to purge |
| binv_ack | input | 1 | Back-invalidate complete |

## Verification
A corrupted state field surfaces on the very next lookup of that region. It appears as a wrong broadcast or speculation decision, one cycle after the request. It also surfaces as a wrong response bit on the next snoop.

A wrong line count is visible only through the forward bit. It therefore shows once the count should have reached zero, for example after saturation followed by as many evictions as the region has lines.

A wrong replacement or recency choice shows as a back-invalidate address naming the wrong region, in the cycle after the conflicting fill. It can also show as a region that still hits after it should have been displaced.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    typedef enum logic [2:0] {
        RS_I  = 3'b000,
        RS_CI = 3'b001,
        RS_CC = 3'b010,
        RS_CD = 3'b011,
        RS_DI = 3'b101,
        RS_DC = 3'b110,
        RS_DD = 3'b111
    } rstate_e;

    localparam logic [1:0] EXT_NONE  = 2'b01;
    localparam logic [1:0] EXT_CLEAN = 2'b10;
    localparam logic [1:0] EXT_DIRTY = 2'b11;

    // Broadcast decision from the remote half of the state.
    function automatic logic bcast_needed(logic [2:0] s, logic want_mod);
        case (s[1:0])
            EXT_NONE:  return 1'b0;
            EXT_CLEAN: return want_mod;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic spec_allowed(logic [2:0] s, logic want_mod, logic no_unknown);
        if (!bcast_needed(s, want_mod))         return 1'b0;
        if (s[1:0] == EXT_DIRTY)                return 1'b0;
        if (s == RS_I && no_unknown)            return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [2:0] compose(logic local_dirty, logic [1:0] ext);
        return {local_dirty, ext};
    endfunction

    function automatic logic [1:0] resp_to_ext(logic clean, logic dirty);
        return dirty ? EXT_DIRTY : (clean ? EXT_CLEAN : EXT_NONE);
    endfunction

    function automatic logic [1:0] snoop_ext(logic [1:0] ext, logic want_mod);
        return (want_mod || ext == EXT_DIRTY) ? EXT_DIRTY : EXT_CLEAN;
    endfunction

endpackage

// File: rtl/rgn_lookup.sv
module rgn_lookup
    import rgn_pkg::*;
#(
    parameter int TAG_W = 19,
    parameter int CNT_W = 4,
    parameter int WAYS  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TAG_W-1:0]              key,
    input  logic [WAYS-1:0][TAG_W-1:0]    tags,
    input  logic [WAYS-1:0][2:0]          sts,
    input  logic [WAYS-1:0][CNT_W-1:0]    cnts,
    output logic                          hit,
    output logic [$clog2(WAYS)-1:0]       way,
    output logic [2:0]                    st,
    output logic [CNT_W-1:0]              cnt
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = (sts[w] != RS_I) && (tags[w] == key);
    end

    always_comb begin
        hit = |match;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way = WAY_W'(w);
        end
        st  = hit ? sts[way] : RS_I;
        cnt = cnts[way];
    end

    // A region may live in only one way of its set.
    p_unique_tag_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(match));

endmodule

// File: rtl/rgn_victim.sv
module rgn_victim #(
    parameter int WAYS = 2
) (
    input  logic [WAYS-1:0]         valid,
    input  logic [WAYS-1:0]         zero,
    input  logic [$clog2(WAYS)-1:0] lru,
    output logic [$clog2(WAYS)-1:0] way,
    output logic                    need_binv
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] free_w;
    logic [WAY_W-1:0] zero_w;

    always_comb begin
        free_w = '0;
        zero_w = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) free_w = WAY_W'(w);
            if (zero[w])   zero_w = WAY_W'(w);
        end
        need_binv = 1'b0;
        if (|(~valid))      way = free_w;
        else if (zero[lru]) way = lru;
        else if (|zero)     way = zero_w;
        else begin
            way       = lru;
            need_binv = 1'b1;
        end
    end

endmodule

// File: rtl/region_tracker.sv
module region_tracker
    import rgn_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BITS   = 6,
    parameter int REGION_BITS = 9,
    parameter int SET_BITS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_nospec_unknown,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_want_mod,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [2:0]        rsp_state,
    output logic              rsp_bcast,
    output logic              rsp_spec_ok,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_want_mod,
    output logic              snp_rsp_valid,
    output logic              snp_ext_clean,
    output logic              snp_ext_dirty,
    output logic              snp_fwd,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic              fill_bcast,
    input  logic              fill_ext_clean,
    input  logic              fill_ext_dirty,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              busy,
    output logic              binv_req,
    output logic [ADDR_W-1:0] binv_addr,
    input  logic              binv_ack
);
    localparam int LINES  = 1 << (REGION_BITS - LINE_BITS);
    localparam int CNT_W  = $clog2(LINES + 1);
    localparam int TAG_W  = ADDR_W - REGION_BITS - SET_BITS;
    localparam int SETS   = 1 << SET_BITS;
    localparam int WAYS   = 2;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int NCH    = 4;
    localparam int CH_REQ = 0;
    localparam int CH_SNP = 1;
    localparam int CH_FIL = 2;
    localparam int CH_EVC = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LINES);

    // Region array storage
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [2:0]       st_q   [SETS][WAYS];
    logic [CNT_W-1:0] cnt_q  [SETS][WAYS];
    logic [WAY_W-1:0] plru_q [SETS];

    logic unused_low;
    assign unused_low = ^{req_addr[REGION_BITS-1:0], snp_addr[REGION_BITS-1:0],
                          fill_addr[REGION_BITS-1:0], evict_addr[REGION_BITS-1:0]};

    // Four read channels share one lookup structure
    logic [SET_BITS-1:0] ch_set [NCH];
    logic [TAG_W-1:0]    ch_tag [NCH];
    logic                ch_hit [NCH];
    logic [WAY_W-1:0]    ch_way [NCH];
    logic [2:0]          ch_st  [NCH];
    logic [CNT_W-1:0]    ch_cnt [NCH];

    assign ch_set[CH_REQ] = req_addr[REGION_BITS +: SET_BITS];
    assign ch_set[CH_SNP] = snp_addr[REGION_BITS +: SET_BITS];
    assign ch_set[CH_FIL] = fill_addr[REGION_BITS +: SET_BITS];
    assign ch_set[CH_EVC] = evict_addr[REGION_BITS +: SET_BITS];
    assign ch_tag[CH_REQ] = req_addr[ADDR_W-1 -: TAG_W];
    assign ch_tag[CH_SNP] = snp_addr[ADDR_W-1 -: TAG_W];
    assign ch_tag[CH_FIL] = fill_addr[ADDR_W-1 -: TAG_W];
    assign ch_tag[CH_EVC] = evict_addr[ADDR_W-1 -: TAG_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [WAYS-1:0][TAG_W-1:0] t;
        logic [WAYS-1:0][2:0]       s;
        logic [WAYS-1:0][CNT_W-1:0] n;
        for (genvar w = 0; w < WAYS; w++) begin : g_w
            assign t[w] = tag_q[ch_set[c]][w];
            assign s[w] = st_q[ch_set[c]][w];
            assign n[w] = cnt_q[ch_set[c]][w];
        end
        rgn_lookup #(.TAG_W(TAG_W), .CNT_W(CNT_W), .WAYS(WAYS)) u_lk (
            .clk  (clk),
            .rst  (rst),
            .key  (ch_tag[c]),
            .tags (t),
            .sts  (s),
            .cnts (n),
            .hit  (ch_hit[c]),
            .way  (ch_way[c]),
            .st   (ch_st[c]),
            .cnt  (ch_cnt[c])
        );
    end

    // Victim choice for the fill set
    logic [WAYS-1:0]  f_valid;
    logic [WAYS-1:0]  f_zero;
    logic [WAY_W-1:0] v_way;
    logic             v_binv;

    for (genvar w = 0; w < WAYS; w++) begin : g_fz
        assign f_valid[w] = st_q[ch_set[CH_FIL]][w] != RS_I;
        assign f_zero[w]  = cnt_q[ch_set[CH_FIL]][w] == '0;
    end

    rgn_victim #(.WAYS(WAYS)) u_vic (
        .valid     (f_valid),
        .zero      (f_zero),
        .lru       (plru_q[ch_set[CH_FIL]]),
        .way       (v_way),
        .need_binv (v_binv)
    );

    // Pending install while a back-invalidate is outstanding
    logic                pend_q;
    logic [SET_BITS-1:0] pend_set_q;
    logic [WAY_W-1:0]    pend_way_q;
    logic [TAG_W-1:0]    pend_tag_q;
    logic [2:0]          pend_st_q;

    // Single write port: install > fill > line eviction > snoop
    logic                wr_en;
    logic                wr_touch;
    logic [SET_BITS-1:0] wr_set;
    logic [WAY_W-1:0]    wr_way;
    logic [TAG_W-1:0]    wr_tag;
    logic [2:0]          wr_st;
    logic [CNT_W-1:0]    wr_cnt;
    logic                start_binv;
    logic [1:0]          fill_resp;

    assign fill_resp = resp_to_ext(fill_ext_clean, fill_ext_dirty);

    always_comb begin
        wr_en      = 1'b0;
        wr_touch   = 1'b0;
        wr_set     = '0;
        wr_way     = '0;
        wr_tag     = '0;
        wr_st      = RS_I;
        wr_cnt     = '0;
        start_binv = 1'b0;
        if (pend_q && binv_ack) begin
            wr_en    = 1'b1;
            wr_touch = 1'b1;
            wr_set   = pend_set_q;
            wr_way   = pend_way_q;
            wr_tag   = pend_tag_q;
            wr_st    = pend_st_q;
            wr_cnt   = CNT_W'(1);
        end else if (fill_valid && !pend_q) begin
            wr_set = ch_set[CH_FIL];
            wr_tag = ch_tag[CH_FIL];
            if (ch_hit[CH_FIL]) begin
                wr_en    = 1'b1;
                wr_touch = 1'b1;
                wr_way   = ch_way[CH_FIL];
                wr_st    = compose(ch_st[CH_FIL][2] | fill_dirty,
                                   fill_bcast ? fill_resp : ch_st[CH_FIL][1:0]);
                wr_cnt   = (ch_cnt[CH_FIL] == CNT_MAX) ? CNT_MAX : ch_cnt[CH_FIL] + CNT_W'(1);
            end else if (!v_binv) begin
                wr_en    = 1'b1;
                wr_touch = 1'b1;
                wr_way   = v_way;
                wr_st    = compose(fill_dirty, fill_resp);
                wr_cnt   = CNT_W'(1);
            end else begin
                start_binv = 1'b1;
            end
        end else if (evict_valid && ch_hit[CH_EVC]) begin
            wr_en  = 1'b1;
            wr_set = ch_set[CH_EVC];
            wr_way = ch_way[CH_EVC];
            wr_tag = ch_tag[CH_EVC];
            wr_st  = ch_st[CH_EVC];
            wr_cnt = (ch_cnt[CH_EVC] == '0) ? '0 : ch_cnt[CH_EVC] - CNT_W'(1);
        end else if (snp_valid && ch_hit[CH_SNP]) begin
            wr_en  = 1'b1;
            wr_set = ch_set[CH_SNP];
            wr_way = ch_way[CH_SNP];
            wr_tag = ch_tag[CH_SNP];
            wr_st  = compose(ch_st[CH_SNP][2], snoop_ext(ch_st[CH_SNP][1:0], snp_want_mod));
            wr_cnt = ch_cnt[CH_SNP];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    st_q[s][w]  <= RS_I;
                    cnt_q[s][w] <= '0;
                end
            end
            pend_q     <= 1'b0;
            pend_set_q <= '0;
            pend_way_q <= '0;
            pend_tag_q <= '0;
            pend_st_q  <= RS_I;
            binv_addr  <= '0;
        end else begin
            if (req_valid && ch_hit[CH_REQ]) plru_q[ch_set[CH_REQ]] <= ~ch_way[CH_REQ];
            if (wr_en) begin
                tag_q[wr_set][wr_way] <= wr_tag;
                st_q[wr_set][wr_way]  <= wr_st;
                cnt_q[wr_set][wr_way] <= wr_cnt;
            end
            if (wr_touch) plru_q[wr_set] <= ~wr_way;
            if (start_binv) begin
                pend_q     <= 1'b1;
                pend_set_q <= ch_set[CH_FIL];
                pend_way_q <= v_way;
                pend_tag_q <= ch_tag[CH_FIL];
                pend_st_q  <= compose(fill_dirty, fill_resp);
                binv_addr  <= {tag_q[ch_set[CH_FIL]][v_way], ch_set[CH_FIL], {REGION_BITS{1'b0}}};
            end else if (pend_q && binv_ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign busy     = pend_q;
    assign binv_req = pend_q;

    // Registered answers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_state     <= RS_I;
            rsp_bcast     <= 1'b0;
            rsp_spec_ok   <= 1'b0;
            snp_rsp_valid <= 1'b0;
            snp_ext_clean <= 1'b0;
            snp_ext_dirty <= 1'b0;
            snp_fwd       <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_hit       <= req_valid && ch_hit[CH_REQ];
            rsp_state     <= req_valid ? ch_st[CH_REQ] : RS_I;
            rsp_bcast     <= req_valid && bcast_needed(ch_st[CH_REQ], req_want_mod);
            rsp_spec_ok   <= req_valid && spec_allowed(ch_st[CH_REQ], req_want_mod, cfg_nospec_unknown);
            snp_rsp_valid <= snp_valid;
            snp_ext_clean <= snp_valid && ch_hit[CH_SNP] && !ch_st[CH_SNP][2];
            snp_ext_dirty <= snp_valid && ch_hit[CH_SNP] && ch_st[CH_SNP][2];
            snp_fwd       <= snp_valid && ch_hit[CH_SNP] && (ch_cnt[CH_SNP] != '0);
        end
    end

    p_direct_nospec_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_bcast |-> !rsp_spec_ok);
    p_dirty_nospec_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_state[1:0] == EXT_DIRTY |-> !rsp_spec_ok);
    p_miss_is_i_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_bcast && rsp_state == RS_I);
    p_fwd_tracked_r7: assert property (@(posedge clk) disable iff (rst)
        snp_fwd |-> snp_rsp_valid && (snp_ext_clean || snp_ext_dirty));
    p_resp_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(snp_ext_clean && snp_ext_dirty));
    p_binv_hold_r11: assert property (@(posedge clk) disable iff (rst)
        binv_req && !binv_ack |=> binv_req && $stable(binv_addr));
    p_ack_install_r11: assert property (@(posedge clk) disable iff (rst)
        binv_req && binv_ack |=> !busy);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_cnt <= CNT_MAX);

endmodule

// File: tb/sim_region_tracker.sv
module sim_region_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_nospec_unknown = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_want_mod = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_bcast, rsp_spec_ok;
    logic [2:0]  rsp_state;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        snp_want_mod = 1'b0;
    logic        snp_rsp_valid, snp_ext_clean, snp_ext_dirty, snp_fwd;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_dirty = 1'b0, fill_bcast = 1'b0, fill_ext_clean = 1'b0, fill_ext_dirty = 1'b0;
    logic        evict_valid = 1'b0;
    logic [31:0] evict_addr = '0;
    logic        busy, binv_req;
    logic [31:0] binv_addr;
    logic        binv_ack = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    region_tracker u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side model of the requirements
    logic [18:0] m_tag [16][2];
    logic [2:0]  m_st  [16][2];
    int          m_cnt [16][2];
    int          m_plru[16];

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(int t, int s, int ln);
        logic [18:0] tt = t[18:0];
        logic [3:0]  ss = s[3:0];
        logic [2:0]  ll = ln[2:0];
        return {tt, ss, ll, 6'd0};
    endfunction

    function automatic int set_of(logic [31:0] a);
        return int'(a[12:9]);
    endfunction

    function automatic bit e_bcast(logic [2:0] s, bit want);
        case (s[1:0])
            2'b01:   return 0;
            2'b10:   return want;
            default: return 1;
        endcase
    endfunction

    function automatic bit e_spec(logic [2:0] s, bit want, bit cfg);
        if (!e_bcast(s, want)) return 0;
        if (s[1:0] == 2'b11)   return 0;
        if (s == 3'b000 && cfg) return 0;
        return 1;
    endfunction

    function automatic logic [1:0] e_resp(bit c, bit d);
        return d ? 2'b11 : (c ? 2'b10 : 2'b01);
    endfunction

    task automatic find(input logic [31:0] a, output bit hit, output int way);
        int s = set_of(a);
        hit = 0;
        way = 0;
        for (int w = 0; w < 2; w++)
            if (m_st[s][w] != 3'b000 && m_tag[s][w] == a[31:13]) begin
                hit = 1;
                way = w;
            end
    endtask

    task automatic do_lookup(input logic [31:0] a, input bit want, input bit cfg);
        bit h;
        int w;
        logic [2:0] es;
        @(negedge clk);
        req_valid = 1;
        req_addr = a;
        req_want_mod = want;
        cfg_nospec_unknown = cfg;
        @(negedge clk);
        req_valid = 0;
        find(a, h, w);
        es = h ? m_st[set_of(a)][w] : 3'b000;
        chk("R2", "rsp_valid", rsp_valid, 1);
        chk("R1", "rsp_hit", rsp_hit, h);
        chk("R5", "rsp_state", rsp_state, es);
        chk("R3", "rsp_bcast", rsp_bcast, e_bcast(es, want));
        chk("R4", "rsp_spec_ok", rsp_spec_ok, e_spec(es, want, cfg));
        if (h) m_plru[set_of(a)] = 1 - w;
    endtask

    task automatic do_snoop(input logic [31:0] a, input bit want);
        bit h;
        int w;
        int s = set_of(a);
        @(negedge clk);
        snp_valid = 1;
        snp_addr = a;
        snp_want_mod = want;
        @(negedge clk);
        snp_valid = 0;
        find(a, h, w);
        chk("R6", "snp_rsp_valid", snp_rsp_valid, 1);
        chk("R6", "snp_ext_clean", snp_ext_clean, h && !m_st[s][w][2]);
        chk("R6", "snp_ext_dirty", snp_ext_dirty, h && m_st[s][w][2]);
        chk("R7", "snp_fwd", snp_fwd, h && m_cnt[s][w] != 0);
        if (h) m_st[s][w][1:0] = (want || m_st[s][w][1:0] == 2'b11) ? 2'b11 : 2'b10;
    endtask

    task automatic do_evict(input logic [31:0] a);
        bit h;
        int w;
        @(negedge clk);
        evict_valid = 1;
        evict_addr = a;
        @(negedge clk);
        evict_valid = 0;
        find(a, h, w);
        if (h && m_cnt[set_of(a)][w] > 0) m_cnt[set_of(a)][w]--;
    endtask

    task automatic do_fill(input logic [31:0] a, input bit dty, input bit bc, input bit ec, input bit ed,
                           input int dly, input bit poke, input logic [31:0] poke_addr);
        bit h;
        int w;
        int s = set_of(a);
        bit need;
        logic [2:0] nst;
        @(negedge clk);
        fill_valid = 1;
        fill_addr = a;
        fill_dirty = dty;
        fill_bcast = bc;
        fill_ext_clean = ec;
        fill_ext_dirty = ed;
        @(negedge clk);
        fill_valid = 0;
        find(a, h, w);
        need = 0;
        if (h) begin
            m_st[s][w] = {m_st[s][w][2] | dty, bc ? e_resp(ec, ed) : m_st[s][w][1:0]};
            if (m_cnt[s][w] < LINES) m_cnt[s][w]++;
            m_plru[s] = 1 - w;
        end else begin
            nst = {dty, e_resp(ec, ed)};
            if (m_st[s][0] == 0) w = 0;
            else if (m_st[s][1] == 0) w = 1;
            else if (m_cnt[s][m_plru[s]] == 0) w = m_plru[s];
            else if (m_cnt[s][0] == 0) w = 0;
            else if (m_cnt[s][1] == 0) w = 1;
            else begin
                w = m_plru[s];
                need = 1;
            end
            chk("R10", "busy after fill", busy, need);
            if (need) begin
                chk("R11", "binv_req", binv_req, 1);
                // R12: victim is the least recently used way
                chk("R11 R12", "binv_addr", binv_addr, {m_tag[s][w], s[3:0], 9'd0});
                if (poke) begin
                    fill_valid = 1;
                    fill_addr = poke_addr;
                end
                for (int i = 0; i < dly; i++) begin
                    @(negedge clk);
                    fill_valid = 0;
                    chk("R11", "busy held", busy, 1);
                end
                binv_ack = 1;
                @(negedge clk);
                binv_ack = 0;
                fill_valid = 0;
                chk("R11", "busy released", busy, 0);
            end
            m_tag[s][w] = a[31:13];
            m_st[s][w] = nst;
            m_cnt[s][w] = 1;
            m_plru[s] = 1 - w;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] ra, zq, yq;
        void'($urandom(32'd4242));
        for (int s = 0; s < 16; s++) begin
            m_plru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = '0;
                m_st[s][w] = 3'b000;
                m_cnt[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1", "busy at reset", busy, 0);

        // R1, R4: untracked region
        do_lookup(mk(1, 2, 0), 0, 0);
        do_lookup(mk(1, 2, 0), 0, 1);
        // R5: exclusive fill with no sharers gives DI
        do_fill(mk(1, 2, 3), 1, 1, 0, 0, 0, 0, '0);
        do_lookup(mk(1, 2, 5), 1, 0);
        chk("R5", "DI after exclusive fill", rsp_state, 3'b101);
        // R6, R7, R8: other side wants ownership, both end dirty-dirty
        do_snoop(mk(1, 2, 1), 1);
        do_lookup(mk(1, 2, 0), 0, 0);
        chk("R8", "DD after ownership snoop", rsp_state, 3'b111);
        // R3: clean-clean region
        do_fill(mk(2, 4, 0), 0, 1, 1, 0, 0, 0, '0);
        do_lookup(mk(2, 4, 1), 0, 0);
        do_lookup(mk(2, 4, 1), 1, 0);
        // R8: read snoop on clean-invalid
        do_fill(mk(3, 6, 0), 0, 1, 0, 0, 0, 0, '0);
        do_snoop(mk(3, 6, 2), 0);
        do_lookup(mk(3, 6, 2), 0, 0);
        chk("R8", "CC after read snoop", rsp_state, 3'b010);
        // R6: snoop to untracked region
        do_snoop(mk(9, 7, 0), 1);
        // R9: count to zero filters snoops, saturation
        do_evict(mk(2, 4, 0));
        do_snoop(mk(2, 4, 0), 0);
        chk("R7", "filtered at zero count", snp_fwd, 0);
        for (int i = 0; i < LINES + 2; i++) do_fill(mk(2, 4, i % 8), 0, 0, 0, 1, 0, 0, '0);
        do_lookup(mk(2, 4, 0), 0, 0);
        chk("R5", "unbroadcast fill keeps remote bits", rsp_state, 3'b010);
        for (int i = 0; i < LINES; i++) do_evict(mk(2, 4, i));
        do_snoop(mk(2, 4, 0), 0);
        chk("R9", "saturated count reaches zero", snp_fwd, 0);
        do_evict(mk(2, 4, 0));
        do_fill(mk(2, 4, 0), 0, 0, 0, 0, 0, 0, '0);
        do_snoop(mk(2, 4, 0), 0);
        chk("R9", "no underflow", snp_fwd, 1);

        // R10, R11, R12: replacement in set 3
        do_fill(mk(10, 3, 0), 0, 1, 0, 0, 0, 0, '0);
        yq = mk(11, 3, 0);
        do_fill(yq, 0, 1, 0, 0, 0, 0, '0);
        do_evict(mk(10, 3, 0));
        zq = mk(12, 3, 0);
        do_fill(zq, 1, 1, 0, 0, 0, 0, '0);
        do_lookup(mk(10, 3, 0), 0, 0);
        chk("R10", "zero-count region displaced", rsp_hit, 0);
        do_lookup(yq, 0, 0);
        chk("R10", "other region kept", rsp_hit, 1);
        do_fill(mk(13, 3, 0), 0, 1, 1, 0, 2, 1, mk(14, 8, 0));
        chk("R12", "victim was least recent", binv_addr, {zq[31:9], 9'd0});
        do_lookup(mk(14, 8, 0), 0, 0);
        chk("R11", "fill ignored while busy", rsp_hit, 0);
        do_lookup(mk(13, 3, 0), 0, 0);
        chk("R11", "installed after ack", rsp_hit, 1);
        do_snoop(mk(13, 3, 0), 0);
        chk("R11", "installed count one", snp_fwd, 1);

        // Constrained random mix over a few conflicting sets
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom_range(0, 5);
            ra = mk($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 7));
            case (op)
                0, 1: do_lookup(ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                2:    do_snoop(ra, 1'($urandom_range(0, 1)));
                3:    do_evict(ra);
                default: do_fill(ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                 $urandom_range(0, 3), 0, '0);
            endcase
        end

        done = 1;
        finish_run();
    end

endmodule